// File: doc/BRIEF.md
# Processor exception entry unit

This block performs the register side of exception entry for a RISC pipeline. The pipeline has already chosen one fault, and it presents that fault as a single-cycle request. The request carries a fault kind, the faulting virtual address, a load/store flag, the address-space identifier, the virtual page number, the PC of the faulting instruction and, for a coprocessor-unusable fault, the coprocessor number.

At the next clock edge the block does all of the following at once:
- issues a one-cycle redirect to the handler address;
- loads the exception code into the cause field;
- sets the exception-level bit of the status register;
- fills whichever of the return-PC, bad-address, TLB entry-high, context and coprocessor-error fields the fault kind requires.

Each of these fields has a write strobe that pulses in that same cycle.

The current bootstrap-vector bit, exception-level bit, interrupt-vector-enable bit and exception-base value come in as inputs from the status and cause registers, which sit outside this block. The handler address is the vector base plus an offset. The offset depends on the fault kind and on those bits.

Top module: `exc_entry_unit`

## Requirements
- R1: After a synchronous active-high reset, every output is zero until the first fault request is accepted.
- R2: A request with `fault_valid` high gives `redirect_valid` high for exactly the next cycle. A cycle with no request gives no redirect and no write strobe.
- R3: The vector base is 0xBFC00200 when `st_bev` is 1, and `ebase` when `st_bev` is 0.
- R4: An interrupt (kind 0) vectors to base+0x200 when `cause_iv` is 1, and to base+0x180 when it is 0.
- R5: A TLB refill (kind 2) vectors to base+0x000 when `st_exl` is 0, and to base+0x180 when it is 1. Every other kind vectors to base+0x180.
- R6: `cause_exc` (cause bits 6:2) takes the code for the kind:
  - interrupt (0): 0;
  - address error (1): 5 for a store, 4 for a load;
  - TLB refill (2) and TLB invalid (3): 3 for a store, 2 for a load;
  - TLB modified (4): 1;
  - syscall (5): 8;
  - breakpoint (6): 9;
  - reserved instruction (7): 10, which is also used for any kind above 10;
  - coprocessor unusable (8): 11;
  - overflow (9): 12;
  - trap (10): 13.
- R7: A TLB fault (kinds 2 to 4) loads `eh_asid` with the ASID, `eh_vpn2` with the VPN shifted right by 2, and `eh_vpn2x` with VPN bits 1:0, and pulses `tlb_wr`. Other kinds leave these fields unchanged.
- R8: A TLB fault loads `ctx_badvpn2` with the VPN shifted right by 2. Other kinds leave it unchanged.
- R9: A coprocessor-unusable fault loads `cause_ce` with `fault_cop` and pulses `ce_wr`. Other kinds leave `cause_ce` unchanged.
- R10: Address-error and TLB faults load `badvaddr_q` with the faulting address and pulse `bad_wr`. Other kinds leave it unchanged.
- R11: Every fault pulses `exl_set`. `epc_q` takes `fault_pc` and `epc_wr` pulses only when `st_exl` is 0. When `st_exl` is 1, `epc_q` keeps its value.
- R12: All field updates and write strobes appear in the same cycle as the redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fault_valid | input | 1 | Fault request, one cycle |
| fault_kind | input | 4 | Fault kind encoding (see R6) |
| fault_vaddr | input | 32 | Faulting virtual address |
| fault_store | input | 1 | 1 = store access, 0 = load |
| fault_asid | input | 8 | Address-space identifier |
| fault_vpn | input | 19 | Virtual page number |
| fault_pc | input | 32 | PC of the faulting instruction |
| fault_cop | input | 2 | Coprocessor number |
| st_bev | input | 1 | Current bootstrap-vector bit |
| st_exl | input | 1 | Current exception-level bit |
| cause_iv | input | 1 | Current interrupt-vector-enable bit |
| ebase | input | 32 | Programmable exception base |
| redirect_valid | output | 1 | PC redirect pulse |
| redirect_pc | output | 32 | Handler address |
| exl_set | output | 1 | Set exception-level strobe |
| cause_exc | output | 5 | Cause exception code |
| cause_ce | output | 2 | Cause coprocessor-error field |
| ce_wr | output | 1 | Coprocessor-error write strobe |
| epc_q | output | 32 | Return PC |
| epc_wr | output | 1 | Return-PC write strobe |
| badvaddr_q | output | 32 | Bad virtual address |
| bad_wr | output | 1 | Bad-address write strobe |
| eh_asid | output | 8 | Entry-high ASID field |
| eh_vpn2 | output | 17 | Entry-high VPN2 field |
| eh_vpn2x | output | 2 | Entry-high VPN2 extension |
| ctx_badvpn2 | output | 17 | Context bad-VPN2 field |
| tlb_wr | output | 1 | Entry-high/context write strobe |

## Verification
The bench drives every fault kind under all eight combinations of bootstrap, vector-enable and exception-level bits, then adds random requests, so several faults can be checked directly:
- A refill whose offset ignored `st_exl` would land at base+0x000 during a nested exception.
- An interrupt that ignored `cause_iv` would miss the 0x200 entry.
- A design that overwrote the return PC while already at exception level would lose the outer handler's return point; the bench detects this by comparing `epc_q` against a model held across later faults.

Fields that must be left alone (the bad address, entry-high, context and coprocessor-error fields) are compared against that same model after every non-qualifying fault. The idle cycle after each redirect confirms that the pulse lasts one cycle.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [3:0] {
    FK_INTERRUPT = 4'd0,
    FK_ADDR_ERR  = 4'd1,
    FK_TLB_REFILL= 4'd2,
    FK_TLB_INVAL = 4'd3,
    FK_TLB_MOD   = 4'd4,
    FK_SYSCALL   = 4'd5,
    FK_BREAK     = 4'd6,
    FK_RESV_INSN = 4'd7,
    FK_COP_UNUSE = 4'd8,
    FK_OVERFLOW  = 4'd9,
    FK_TRAP      = 4'd10
  } fault_kind_e;

  localparam int CODE_W = 5;
  localparam logic [CODE_W-1:0] EC_INT  = 5'd0;
  localparam logic [CODE_W-1:0] EC_MOD  = 5'd1;
  localparam logic [CODE_W-1:0] EC_TLBL = 5'd2;
  localparam logic [CODE_W-1:0] EC_TLBS = 5'd3;
  localparam logic [CODE_W-1:0] EC_ADEL = 5'd4;
  localparam logic [CODE_W-1:0] EC_ADES = 5'd5;
  localparam logic [CODE_W-1:0] EC_SYS  = 5'd8;
  localparam logic [CODE_W-1:0] EC_BP   = 5'd9;
  localparam logic [CODE_W-1:0] EC_RI   = 5'd10;
  localparam logic [CODE_W-1:0] EC_CPU  = 5'd11;
  localparam logic [CODE_W-1:0] EC_OV   = 5'd12;
  localparam logic [CODE_W-1:0] EC_TR   = 5'd13;
endpackage

// File: rtl/exc_code_map.sv
module exc_code_map
  import exc_pkg::*;
(
  input  logic [3:0]        kind,
  input  logic              store,
  output logic [CODE_W-1:0] code,
  output logic              uses_addr,
  output logic              is_tlb,
  output logic              is_cop
);
  always_comb begin
    uses_addr = 1'b0;
    is_tlb    = 1'b0;
    is_cop    = 1'b0;
    unique case (kind)
      FK_INTERRUPT: code = EC_INT;
      FK_ADDR_ERR: begin
        code      = store ? EC_ADES : EC_ADEL;
        uses_addr = 1'b1;
      end
      FK_TLB_REFILL, FK_TLB_INVAL: begin
        code      = store ? EC_TLBS : EC_TLBL;
        uses_addr = 1'b1;
        is_tlb    = 1'b1;
      end
      FK_TLB_MOD: begin
        code      = EC_MOD;
        uses_addr = 1'b1;
        is_tlb    = 1'b1;
      end
      FK_SYSCALL:   code = EC_SYS;
      FK_BREAK:     code = EC_BP;
      FK_COP_UNUSE: begin
        code   = EC_CPU;
        is_cop = 1'b1;
      end
      FK_OVERFLOW:  code = EC_OV;
      FK_TRAP:      code = EC_TR;
      default:      code = EC_RI;
    endcase
  end
endmodule

// File: rtl/exc_vector_calc.sv
module exc_vector_calc
  import exc_pkg::*;
#(
  parameter int                XLEN      = 32,
  parameter logic [XLEN-1:0]   BOOT_BASE = 32'hBFC0_0200,
  parameter logic [XLEN-1:0]   OFS_GEN   = 'h180,
  parameter logic [XLEN-1:0]   OFS_VINT  = 'h200,
  parameter logic [XLEN-1:0]   OFS_REFL  = 'h000
) (
  input  logic [3:0]      kind,
  input  logic            bev,
  input  logic            iv,
  input  logic            exl,
  input  logic [XLEN-1:0] ebase,
  output logic [XLEN-1:0] vector
);
  logic [XLEN-1:0] base_sel;
  logic [XLEN-1:0] ofs_sel;

  always_comb begin
    base_sel = bev ? BOOT_BASE : ebase;
    if (kind == FK_INTERRUPT)
      ofs_sel = iv ? OFS_VINT : OFS_GEN;
    else if (kind == FK_TLB_REFILL)
      ofs_sel = exl ? OFS_GEN : OFS_REFL;
    else
      ofs_sel = OFS_GEN;
    vector = base_sel + ofs_sel;
  end
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int ASID_W = 8,
  parameter int VPN_W  = 19,
  parameter int COP_W  = 2,
  localparam int VPN2_W = VPN_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fault_valid,
  input  logic [3:0]        fault_kind,
  input  logic [XLEN-1:0]   fault_vaddr,
  input  logic              fault_store,
  input  logic [ASID_W-1:0] fault_asid,
  input  logic [VPN_W-1:0]  fault_vpn,
  input  logic [XLEN-1:0]   fault_pc,
  input  logic [COP_W-1:0]  fault_cop,
  input  logic              st_bev,
  input  logic              st_exl,
  input  logic              cause_iv,
  input  logic [XLEN-1:0]   ebase,
  output logic              redirect_valid,
  output logic [XLEN-1:0]   redirect_pc,
  output logic              exl_set,
  output logic [4:0]        cause_exc,
  output logic [COP_W-1:0]  cause_ce,
  output logic              ce_wr,
  output logic [XLEN-1:0]   epc_q,
  output logic              epc_wr,
  output logic [XLEN-1:0]   badvaddr_q,
  output logic              bad_wr,
  output logic [ASID_W-1:0] eh_asid,
  output logic [VPN2_W-1:0] eh_vpn2,
  output logic [1:0]        eh_vpn2x,
  output logic [VPN2_W-1:0] ctx_badvpn2,
  output logic              tlb_wr
);
  logic [CODE_W-1:0] code_d;
  logic              uses_addr, is_tlb, is_cop;
  logic [XLEN-1:0]   vector_d;

  exc_code_map u_code (
    .kind      (fault_kind),
    .store     (fault_store),
    .code      (code_d),
    .uses_addr (uses_addr),
    .is_tlb    (is_tlb),
    .is_cop    (is_cop)
  );

  exc_vector_calc #(.XLEN(XLEN)) u_vec (
    .kind   (fault_kind),
    .bev    (st_bev),
    .iv     (cause_iv),
    .exl    (st_exl),
    .ebase  (ebase),
    .vector (vector_d)
  );

  // Strobes: one-cycle pulses, qualified by the request
  always_ff @(posedge clk) begin
    if (rst) begin
      redirect_valid <= 1'b0;
      exl_set        <= 1'b0;
      epc_wr         <= 1'b0;
      bad_wr         <= 1'b0;
      tlb_wr         <= 1'b0;
      ce_wr          <= 1'b0;
    end else begin
      redirect_valid <= fault_valid;
      exl_set        <= fault_valid;
      epc_wr         <= fault_valid && !st_exl;
      bad_wr         <= fault_valid && uses_addr;
      tlb_wr         <= fault_valid && is_tlb;
      ce_wr          <= fault_valid && is_cop;
    end
  end

  // Held field values
  always_ff @(posedge clk) begin
    if (rst) begin
      redirect_pc <= '0;
      cause_exc   <= '0;
      cause_ce    <= '0;
      epc_q       <= '0;
      badvaddr_q  <= '0;
      eh_asid     <= '0;
      eh_vpn2     <= '0;
      eh_vpn2x    <= '0;
      ctx_badvpn2 <= '0;
    end else if (fault_valid) begin
      redirect_pc <= vector_d;
      cause_exc   <= code_d;
      if (is_cop)    cause_ce   <= fault_cop;
      if (!st_exl)   epc_q      <= fault_pc;
      if (uses_addr) badvaddr_q <= fault_vaddr;
      if (is_tlb) begin
        eh_asid     <= fault_asid;
        eh_vpn2     <= fault_vpn[VPN_W-1:2];
        eh_vpn2x    <= fault_vpn[1:0];
        ctx_badvpn2 <= fault_vpn[VPN_W-1:2];
      end
    end
  end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import exc_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int VPN_W = 19,
  parameter int COP_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             fault_valid,
  input logic [3:0]       fault_kind,
  input logic [VPN_W-1:0] fault_vpn,
  input logic             st_bev,
  input logic             st_exl,
  input logic             redirect_valid,
  input logic [XLEN-1:0]  redirect_pc,
  input logic             exl_set,
  input logic [COP_W-1:0] cause_ce,
  input logic             ce_wr,
  input logic [XLEN-1:0]  epc_q,
  input logic             epc_wr,
  input logic             bad_wr,
  input logic             tlb_wr,
  input logic [1:0]       eh_vpn2x
);
  // R2
  redirect_follows_chk: assert property (@(posedge clk) disable iff (rst)
    fault_valid |=> redirect_valid);
  // R2
  no_spurious_redirect_chk: assert property (@(posedge clk) disable iff (rst)
    !fault_valid |=> !redirect_valid && !exl_set);
  // R3
  boot_vector_chk: assert property (@(posedge clk) disable iff (rst)
    fault_valid && st_bev && fault_kind == FK_SYSCALL |=> redirect_pc == 32'hBFC0_0380);
  // R7
  vpn_ext_chk: assert property (@(posedge clk) disable iff (rst)
    fault_valid && fault_kind == FK_TLB_REFILL |=> eh_vpn2x == $past(fault_vpn[1:0]));
  // R9
  ce_hold_chk: assert property (@(posedge clk) disable iff (rst)
    fault_valid && fault_kind != FK_COP_UNUSE |=> $stable(cause_ce) && !ce_wr);
  // R11
  epc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    fault_valid && st_exl |=> !epc_wr && $stable(epc_q));
  // R12
  strobe_align_chk: assert property (@(posedge clk) disable iff (rst)
    (epc_wr || bad_wr || tlb_wr || ce_wr || exl_set) |-> redirect_valid);
endmodule

bind exc_entry_unit exc_entry_chk #(.XLEN(XLEN), .VPN_W(VPN_W), .COP_W(COP_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .fault_valid    (fault_valid),
  .fault_kind     (fault_kind),
  .fault_vpn      (fault_vpn),
  .st_bev         (st_bev),
  .st_exl         (st_exl),
  .redirect_valid (redirect_valid),
  .redirect_pc    (redirect_pc),
  .exl_set        (exl_set),
  .cause_ce       (cause_ce),
  .ce_wr          (ce_wr),
  .epc_q          (epc_q),
  .epc_wr         (epc_wr),
  .bad_wr         (bad_wr),
  .tlb_wr         (tlb_wr),
  .eh_vpn2x       (eh_vpn2x)
);

// File: tb/exc_entry_unit_test.sv
module exc_entry_unit_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        fault_valid;
  logic [3:0]  fault_kind;
  logic [31:0] fault_vaddr;
  logic        fault_store;
  logic [7:0]  fault_asid;
  logic [18:0] fault_vpn;
  logic [31:0] fault_pc;
  logic [1:0]  fault_cop;
  logic        st_bev, st_exl, cause_iv;
  logic [31:0] ebase;
  logic        redirect_valid, exl_set, ce_wr, epc_wr, bad_wr, tlb_wr;
  logic [31:0] redirect_pc, epc_q, badvaddr_q;
  logic [4:0]  cause_exc;
  logic [1:0]  cause_ce, eh_vpn2x;
  logic [7:0]  eh_asid;
  logic [16:0] eh_vpn2, ctx_badvpn2;

  always #2 clk = ~clk;

  exc_entry_unit uut (.*);

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // model of held fields
  logic [31:0] m_epc, m_bad;
  logic [7:0]  m_asid;
  logic [16:0] m_vpn2, m_ctx;
  logic [1:0]  m_vx, m_ce;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_vec(logic [3:0] k, logic bev, logic iv, logic exl, logic [31:0] eb);
    logic [31:0] b, o;
    b = bev ? 32'hBFC0_0200 : eb;
    if (k == 4'd0)      o = iv  ? 32'h200 : 32'h180;
    else if (k == 4'd2) o = exl ? 32'h180 : 32'h000;
    else                o = 32'h180;
    return b + o;
  endfunction

  function automatic logic [4:0] exp_code(logic [3:0] k, logic st);
    case (k)
      4'd0: return 5'd0;
      4'd1: return st ? 5'd5 : 5'd4;
      4'd2, 4'd3: return st ? 5'd3 : 5'd2;
      4'd4: return 5'd1;
      4'd5: return 5'd8;
      4'd6: return 5'd9;
      4'd8: return 5'd11;
      4'd9: return 5'd12;
      4'd10: return 5'd13;
      default: return 5'd10;
    endcase
  endfunction

  task automatic do_fault(logic [3:0] k, logic st, logic bev, logic iv, logic exl);
    logic tlb, addr, cop;
    @(negedge clk);
    fault_valid = 1'b1; fault_kind = k; fault_store = st;
    st_bev = bev; cause_iv = iv; st_exl = exl;
    fault_vaddr = $urandom; fault_asid = 8'($urandom); fault_vpn = 19'($urandom);
    fault_pc = $urandom & 32'hFFFF_FFFC; fault_cop = 2'($urandom);
    ebase = 32'h8000_0000 | ($urandom & 32'h3FFF_F000);
    tlb  = (k >= 4'd2 && k <= 4'd4);
    addr = (k >= 4'd1 && k <= 4'd4);
    cop  = (k == 4'd8);
    if (tlb) begin
      m_asid = fault_asid; m_vpn2 = fault_vpn[18:2]; m_vx = fault_vpn[1:0]; m_ctx = fault_vpn[18:2];
    end
    if (addr) m_bad = fault_vaddr;
    if (cop)  m_ce  = fault_cop;
    if (!exl) m_epc = fault_pc;
    @(negedge clk);
    chk("R2 redirect", {31'd0, redirect_valid}, 32'd1);
    chk($sformatf("R3/R4/R5 vector k=%0d bev=%0d iv=%0d exl=%0d", k, bev, iv, exl),
        redirect_pc, exp_vec(k, bev, iv, exl, ebase));
    chk($sformatf("R6 code k=%0d st=%0d", k, st), {27'd0, cause_exc}, {27'd0, exp_code(k, st)});
    chk("R7 eh_asid", {24'd0, eh_asid}, {24'd0, m_asid});
    chk("R7 eh_vpn2", {15'd0, eh_vpn2}, {15'd0, m_vpn2});
    chk("R7 eh_vpn2x", {30'd0, eh_vpn2x}, {30'd0, m_vx});
    chk("R8 ctx", {15'd0, ctx_badvpn2}, {15'd0, m_ctx});
    chk("R9 ce", {30'd0, cause_ce}, {30'd0, m_ce});
    chk("R10 badvaddr", badvaddr_q, m_bad);
    chk("R11 epc", epc_q, m_epc);
    chk("R11 exl_set", {31'd0, exl_set}, 32'd1);
    chk("R12 strobes", {27'd0, epc_wr, bad_wr, tlb_wr, ce_wr, redirect_valid},
        {27'd0, !exl, addr, tlb, cop, 1'b1});
    fault_valid = 1'b0;
    @(negedge clk);
    chk("R2 single pulse", {26'd0, redirect_valid, exl_set, epc_wr, bad_wr, tlb_wr, ce_wr}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst = 1'b1; fault_valid = 1'b0; fault_kind = '0; fault_vaddr = '0; fault_store = 1'b0;
    fault_asid = '0; fault_vpn = '0; fault_pc = '0; fault_cop = '0;
    st_bev = 1'b0; st_exl = 1'b0; cause_iv = 1'b0; ebase = '0;
    m_epc = '0; m_bad = '0; m_asid = '0; m_vpn2 = '0; m_ctx = '0; m_vx = '0; m_ce = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset strobes", {26'd0, redirect_valid, exl_set, epc_wr, bad_wr, tlb_wr, ce_wr}, 32'd0);
    chk("R1 reset pc", redirect_pc, 32'd0);
    chk("R1 reset epc", epc_q, 32'd0);
    chk("R1 reset bad", badvaddr_q, 32'd0);
    chk("R1 reset fields", {cause_exc, cause_ce, eh_vpn2x, eh_asid}, 32'd0);
    // directed: every kind, every bit combination, both access types
    for (int k = 0; k <= 10; k++)
      for (int c = 0; c < 16; c++)
        do_fault(4'(k), c[3], c[2], c[1], c[0]);
    // random
    for (int n = 0; n < 400; n++)
      do_fault(4'($urandom_range(0, 10)), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule